// File: doc/BRIEF.md
# Fastlock Charge-Pump Gain Timer

This block governs the short high-gain window a synthesizer loop uses to settle quickly after a channel change. Every divider-word write carries a gain flag; when fastlock is switched on in the configuration word, a write with that flag set selects the high charge-pump current and pulls the loop-filter switch pin low. The window closes in one of two ways chosen by configuration: either software writes the flag back to 0, or a timer clocked by phase-detector cycles expires and clears the stored flag by itself.

When fastlock is switched off in configuration, the switch pin is a plain general-purpose output that drives the configured level, and the current select stays low. Power-down forces low current, releases the switch pin and reloads the timer so that any open window restarts its full length once power returns. All inputs are single-cycle strobes or static levels; there is no streaming data path, so no valid/ready handshake exists, and a write strobe is accepted in every cycle it is high, with no back-pressure.

Top module: `fastlock_gain_timer`

## Requirements
- R1: After reset the stored gain flag reads 0 and the current select is low.
- R2: With fastlock enabled and no power-down, a divider write with the gain flag 1 makes, from the next cycle on, the current select 1, the switch output enable 1 and the switch output 0.
- R3: With fastlock disabled, the current select is 0, the switch output enable is 1 and the switch output equals the mode-select bit, whatever the stored gain flag.
- R4: In the software-exit mode (mode-select 0), only a divider write with the gain flag 0 clears the stored flag; phase-detector cycles never clear it.
- R5: In the timed mode (mode-select 1), with fastlock enabled, the stored flag clears on the edge that takes the (4*code + 3)-th phase-detector strobe after the write that set it, where code is the 4-bit timer code; it stays set before that strobe.
- R6: A divider write with the gain flag 1 while the timer runs restarts the full timeout from that write.
- R7: While power-down is high the current select is 0, the switch output enable is 0 when fastlock is enabled, and the timer is held at its load value, so after release a full timeout is counted again.
- R8: With fastlock enabled and the stored flag 0, the current select is 0 and the switch output enable is 0.
- R9: The stored gain flag follows each divider write even when fastlock is disabled, and no timer runs then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_down | input | 1 | Power-down level |
| pfd_tick | input | 1 | One-cycle strobe per phase-detector cycle |
| ab_wr | input | 1 | Divider-word write strobe |
| ab_gain | input | 1 | Gain flag carried by the divider write |
| fl_enable | input | 1 | Fastlock enable configuration bit |
| fl_mode_sel | input | 1 | Mode select / general-purpose output level |
| fl_tcode | input | 4 | Timer code |
| cp_high_sel | output | 1 | 1 selects high charge-pump current |
| fls_out | output | 1 | Switch pin drive level |
| fls_oe | output | 1 | Switch pin output enable (0 = high impedance) |
| gain_state | output | 1 | Stored gain flag |

## Verification
The stored flag and timer are registered, so a write or the final timer strobe shows at the outputs one cycle later, after the capturing edge; configuration and power-down act on the outputs in the same cycle through combinational decoding. The bench drives each stimulus between edges, lets exactly one rising edge pass, and samples two nanoseconds later, comparing against a reference model advanced by the same edge. Directed runs count strobes to the boundary cycle of codes 0, 5 and 15 and check the flag on both sides of it.

// File: rtl/fl_gain_pkg.sv
package fl_gain_pkg;
  localparam int unsigned DEF_CODE_W = 4;
  localparam int unsigned DEF_STEP   = 4;
  localparam int unsigned DEF_OFS    = 3;

  typedef enum logic [1:0] {
    SW_HIZ    = 2'd0,
    SW_LOW    = 2'd1,
    SW_FOLLOW = 2'd2
  } sw_drive_e;
endpackage

// File: rtl/fl_timer.sv
module fl_timer #(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned STEP   = 4,
  parameter int unsigned OFS    = 3,
  localparam int unsigned MAXV  = STEP * ((1 << CODE_W) - 1) + OFS,
  localparam int unsigned CNT_W = $clog2(MAXV + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic              load,
  input  logic              hold_pd,
  input  logic              run,
  input  logic              tick,
  output logic              expire
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;

  assign load_val = CNT_W'(code) * CNT_W'(STEP) + CNT_W'(OFS);
  assign expire   = run && tick && !load && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '1;
    else if (load || hold_pd)    cnt <= load_val;
    else if (run && tick && cnt != CNT_W'(1)) cnt <= cnt - CNT_W'(1);
  end

  // R5
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != '0);
  // R7
  pd_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_pd |=> cnt == $past(load_val));
endmodule

// File: rtl/fl_outmux.sv
module fl_outmux
  import fl_gain_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fl_en,
  input  logic mode_sel,
  input  logic gain,
  input  logic pd,
  output logic cp_high,
  output logic sw_out,
  output logic sw_oe
);
  sw_drive_e drive;
  logic      active;

  assign active = fl_en && gain && !pd;

  always_comb begin
    if (!fl_en)      drive = SW_FOLLOW;
    else if (active) drive = SW_LOW;
    else             drive = SW_HIZ;
  end

  always_comb begin
    cp_high = active;
    unique case (drive)
      SW_FOLLOW: begin sw_oe = 1'b1; sw_out = mode_sel; end
      SW_LOW:    begin sw_oe = 1'b1; sw_out = 1'b0;     end
      default:   begin sw_oe = 1'b0; sw_out = 1'b0;     end
    endcase
  end

  // R2
  high_drives_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cp_high |-> (sw_oe && !sw_out));
  // R3
  gpo_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_en |-> (sw_oe && !cp_high && sw_out == mode_sel));
endmodule

// File: rtl/fastlock_gain_timer.sv
module fastlock_gain_timer
  import fl_gain_pkg::*;
#(
  parameter int unsigned CODE_W = DEF_CODE_W,
  parameter int unsigned STEP   = DEF_STEP,
  parameter int unsigned OFS    = DEF_OFS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_down,
  input  logic              pfd_tick,
  input  logic              ab_wr,
  input  logic              ab_gain,
  input  logic              fl_enable,
  input  logic              fl_mode_sel,
  input  logic [CODE_W-1:0] fl_tcode,
  output logic              cp_high_sel,
  output logic              fls_out,
  output logic              fls_oe,
  output logic              gain_state
);
  logic gain_q;
  logic timed_run;
  logic expire;

  assign timed_run  = fl_enable && fl_mode_sel && gain_q && !pwr_down;
  assign gain_state = gain_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      gain_q <= 1'b0;
    else if (ab_wr)  gain_q <= ab_gain;
    else if (expire) gain_q <= 1'b0;
  end

  fl_timer #(.CODE_W(CODE_W), .STEP(STEP), .OFS(OFS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .code    (fl_tcode),
    .load    (ab_wr && ab_gain),
    .hold_pd (pwr_down),
    .run     (timed_run),
    .tick    (pfd_tick),
    .expire  (expire)
  );

  fl_outmux u_mux (
    .clk      (clk),
    .rst_n    (rst_n),
    .fl_en    (fl_enable),
    .mode_sel (fl_mode_sel),
    .gain     (gain_q),
    .pd       (pwr_down),
    .cp_high  (cp_high_sel),
    .sw_out   (fls_out),
    .sw_oe    (fls_oe)
  );

  // R9
  wr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ab_wr |=> gain_q == $past(ab_gain));
  // R4
  hold_unless_timed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_q && !ab_wr && !timed_run) |=> gain_q);
  // R5
  expire_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ab_wr) |=> !gain_q);
endmodule

// File: tb/fastlock_gain_timer_test.sv
module fastlock_gain_timer_test;
  logic clk = 1'b0;
  logic rst_n, pwr_down, pfd_tick, ab_wr, ab_gain, fl_enable, fl_mode_sel;
  logic [3:0] fl_tcode;
  logic cp_high_sel, fls_out, fls_oe, gain_state;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;
  int m_gain = 0, m_cnt = 63;

  always #5 clk = ~clk;

  fastlock_gain_timer uut (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .pfd_tick(pfd_tick),
    .ab_wr(ab_wr), .ab_gain(ab_gain), .fl_enable(fl_enable),
    .fl_mode_sel(fl_mode_sel), .fl_tcode(fl_tcode),
    .cp_high_sel(cp_high_sel), .fls_out(fls_out), .fls_oe(fls_oe),
    .gain_state(gain_state));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  function automatic int ld_val(int c);
    return 4 * c + 3;
  endfunction

  // model of the registered state, advanced once per edge
  task automatic model_edge();
    if (pwr_down) m_cnt = ld_val(fl_tcode);
    if (ab_wr) begin
      m_gain = ab_gain;
      if (ab_gain) m_cnt = ld_val(fl_tcode);
    end else if (fl_enable && fl_mode_sel && m_gain == 1 && !pwr_down && pfd_tick) begin
      if (m_cnt == 1) m_gain = 0;
      else m_cnt--;
    end
  endtask

  task automatic check_model(string req);
    int act_on;
    act_on = (fl_enable && m_gain == 1 && !pwr_down) ? 1 : 0;
    chk({req, " gain"}, gain_state, m_gain);
    chk({req, " cp"}, cp_high_sel, act_on);
    chk({req, " oe"}, fls_oe, (act_on == 1 || !fl_enable) ? 1 : 0);
    chk({req, " out"}, fls_out, fl_enable ? 0 : int'(fl_mode_sel));
  endtask

  task automatic step(bit wr, bit g, bit tk);
    ab_wr = wr; ab_gain = g; pfd_tick = tk;
    @(posedge clk);
    model_edge();
    #2;
    ab_wr = 0; pfd_tick = 0;
  endtask

  task automatic timed_run(int code);
    fl_enable = 1; fl_mode_sel = 1; fl_tcode = 4'(code); pwr_down = 0;
    step(1, 1, 0);
    chk("R2 cp after write", cp_high_sel, 1);
    for (int i = 1; i < ld_val(code); i++) step(0, 0, 1);
    chk("R5 still set before last strobe", gain_state, 1);
    step(0, 0, 1);
    chk("R5 cleared on last strobe", gain_state, 0);
    chk("R8 cp low after timeout", cp_high_sel, 0);
    chk("R8 oe low after timeout", fls_oe, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    rst_n = 0; pwr_down = 0; pfd_tick = 0; ab_wr = 0; ab_gain = 0;
    fl_enable = 1; fl_mode_sel = 0; fl_tcode = 0;
    repeat (3) @(posedge clk);
    #2; rst_n = 1;
    chk("R1 gain after reset", gain_state, 0);
    chk("R1 cp after reset", cp_high_sel, 0);
    chk("R8 oe idle", fls_oe, 0);

    // R2 and R4: software-exit mode
    step(1, 1, 0);
    chk("R2 cp", cp_high_sel, 1);
    chk("R2 oe", fls_oe, 1);
    chk("R2 out", fls_out, 0);
    for (int i = 0; i < 80; i++) step(0, 0, 1);
    chk("R4 ticks do not clear", gain_state, 1);
    step(1, 0, 0);
    chk("R4 write 0 exits", gain_state, 0);
    chk("R4 cp low", cp_high_sel, 0);

    // R5 boundary codes
    timed_run(0);
    timed_run(5);
    timed_run(15);

    // R6 restart
    fl_tcode = 2;
    step(1, 1, 0);
    for (int i = 0; i < 8; i++) step(0, 0, 1);
    step(1, 1, 0);
    for (int i = 0; i < 10; i++) step(0, 0, 1);
    chk("R6 restart keeps flag", gain_state, 1);
    step(0, 0, 1);
    chk("R6 clears after full restart", gain_state, 0);

    // R7 power-down reload
    fl_tcode = 1;
    step(1, 1, 0);
    for (int i = 0; i < 5; i++) step(0, 0, 1);
    pwr_down = 1;
    step(0, 0, 1);
    chk("R7 cp low in pd", cp_high_sel, 0);
    chk("R7 oe low in pd", fls_oe, 0);
    chk("R7 flag kept in pd", gain_state, 1);
    pwr_down = 0;
    for (int i = 0; i < 6; i++) step(0, 0, 1);
    chk("R7 full timeout after pd", gain_state, 1);
    step(0, 0, 1);
    chk("R7 clears after reload", gain_state, 0);

    // R3 and R9: fastlock disabled
    fl_enable = 0; fl_mode_sel = 1;
    step(1, 1, 0);
    chk("R9 flag stored", gain_state, 1);
    chk("R3 cp low", cp_high_sel, 0);
    chk("R3 oe high", fls_oe, 1);
    chk("R3 out follows", fls_out, 1);
    for (int i = 0; i < 70; i++) step(0, 0, 1);
    chk("R9 no timer when disabled", gain_state, 1);
    fl_mode_sel = 0; #1;
    chk("R3 out follows 0", fls_out, 0);

    // random mix against model
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 49) == 0) fl_enable = 1'($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 49) == 0) fl_mode_sel = 1'($urandom);
      if ($urandom_range(0, 29) == 0) fl_tcode = 4'($urandom_range(0, 3));
      if ($urandom_range(0, 39) == 0) pwr_down = ~pwr_down;
      step(1'($urandom_range(0, 24) == 0), 1'($urandom_range(0, 3) != 0),
           1'($urandom_range(0, 1)));
      check_model("R2/R3/R4/R5/R7/R8");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule